// File: doc/BRIEF.md
# Control-Flow Instruction Decoder

This block decodes the program-flow instructions of an 8-bit controller whose instructions are 16 bits wide. It handles relative and absolute jumps and calls, jumps and calls through the Z pointer, returns, conditional branches on a status flag, and the four skip-on-bit tests. For each instruction word presented with `valid_i`, it registers a result one clock later. The result holds a class code and the next program counter to use. It also gives the return address a call must push, whether a branch is taken, the operand selects a skip test needs, and a flag for instructions that the device feature mask disables.

The execute stage presents four things with each instruction: the current word, the word stored after it, the address of that following word, and the live Z pointer, extension register, status flags and feature mask. The word after the current one serves two purposes. For a two-word jump or call it holds the low 16 bits of the target. For a skip it is the instruction that would be skipped, and the block uses it to tell whether two words must be stepped over. Fetch, the stack memory and the register file lie outside the block. Evaluating a skip condition also lies outside it: the block only says which bit of which register or I/O location to test.

Top module: `cf_decoder`

## Requirements
- R1: Relative jump (top nibble 0xC) and relative call (top nibble 0xD) give the target `npc_i` plus the sign-extended 12-bit offset in bits 11:0. The jump has class 1 (jump) and the call has class 2 (call). Class codes are: 0 other, 1 jump, 2 call, 3 return, 4 interrupt return, 5 branch, 6 skip.
- R2: The two-word absolute forms match `1001 010x xxxx 11cx`, where bit 1 is 0 for a jump and 1 for a call. The target is {instr[8:4], instr[0], next_word_i}, cut to PC_W bits.
- R3: 0x9409 jumps and 0x9509 calls to the target {zeros, z_i}. 0x9419 jumps and 0x9519 calls to the target {eind_i, z_i}.
- R4: 0x9508 gives class 3 and 0x9518 gives class 4. In both cases `target_o` is `npc_i`.
- R5: 0xF000-0xF3FF is branch-if-set and 0xF400-0xF7FF is branch-if-clear. Both have class 5. The flag is picked by bits 2:0 from `flags_i`, whose bit n is the flag with index n in the order 0=C, 1=Z, 2=N, 3=V, 4=S, 5=H, 6=T, 7=I. When taken, `taken_o`=1 and the target is `npc_i` plus the sign-extended bits 9:3. When not taken, `taken_o`=0 and the target is `npc_i`. `taken_o` is 0 for every other class.
- R6: `ret_addr_o` is `npc_i` for the one-word calls and `npc_i`+1 for the two-word call. It is 0 for every class other than call.
- R7: A register skip (`1111 11sr rrrr 0bbb`) or an I/O skip (`1001 10s1 AAAA Abbb`) gives class 6. `skip_io_o` is 1 for the I/O forms. `skip_on_set_o` is the s bit. `skip_addr_o` is the 5-bit register or I/O address and `skip_bit_o` is bbb. These four skip fields are 0 for every other class.
- R8: Feature mask bit 0 enables the two-word forms, bit 1 the Z forms and bit 2 the extended Z forms. A disabled instruction gives class 0 with `nop_o`=1. Its target is `npc_i`+1 for a two-word form and `npc_i` otherwise.
- R9: A skip whose following word matches the two-word jump/call pattern has `skip_words_o`=2 and the target `npc_i`+2. Any other skip has `skip_words_o`=1 and the target `npc_i`+1.
- R10: All target and return-address arithmetic wraps modulo 2^PC_W.
- R11: The result appears one clock after `valid_i` with `valid_o`=1. A synchronous reset clears every output to 0.
- R12: A word outside all these forms gives class 0, `nop_o`=0 and the target `npc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Current instruction word |
| next_word_i | input | 16 | Word stored after the current one |
| npc_i | input | PC_W (22) | Word address following `instr_i` |
| z_i | input | 16 | Z pointer {high, low} |
| eind_i | input | PC_W-16 (6) | Extension bits placed above Z |
| flags_i | input | 8 | Status flags, bit n is flag index n |
| feat_i | input | 3 | Device feature enables |
| valid_o | output | 1 | Result valid |
| class_o | output | 3 | Instruction class code |
| target_o | output | PC_W (22) | Next program counter |
| ret_addr_o | output | PC_W (22) | Return address to push |
| taken_o | output | 1 | Conditional branch taken |
| nop_o | output | 1 | Instruction disabled by feature mask |
| skip_io_o | output | 1 | Skip tests an I/O location |
| skip_on_set_o | output | 1 | Skip when tested bit is set |
| skip_addr_o | output | 5 | Register or I/O address to test |
| skip_bit_o | output | 3 | Bit to test |
| skip_words_o | output | 2 | Words to step over when skipping |

## Verification
The assertions check several properties on every cycle. A result follows each accepted word by exactly one clock. `taken_o` and `nop_o` appear only with the branch and other classes. A non-taken branch keeps the sequential address. A skip's target sits exactly `skip_words_o` past the following address. A call's return address is the following address or one past it. The exact field decoding cannot be shown by a property: the flag order, the splicing of the 22-bit absolute target, the extension register placement, feature gating per form and wrap-around at the top of the address space. The bench shows these through directed instruction words with hand-computed targets.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    localparam int INSTR_W = 16;
    localparam int FLAG_W  = 8;
    localparam int FEAT_W  = 3;
    localparam int FEAT_LONG = 0;
    localparam int FEAT_IND  = 1;
    localparam int FEAT_EXT  = 2;

    typedef enum logic [2:0] {
        CF_OTHER  = 3'd0,
        CF_JUMP   = 3'd1,
        CF_CALL   = 3'd2,
        CF_RET    = 3'd3,
        CF_RETI   = 3'd4,
        CF_BRANCH = 3'd5,
        CF_SKIP   = 3'd6
    } cf_class_e;

    typedef enum logic [4:0] {
        OP_NONE, OP_RELJ, OP_RELC, OP_ABSJ, OP_ABSC,
        OP_ZJ, OP_ZC, OP_XJ, OP_XC, OP_RET, OP_RETI,
        OP_BSET, OP_BCLR, OP_RSKC, OP_RSKS, OP_ISKC, OP_ISKS
    } op_kind_e;

    typedef struct packed {
        logic       from_io;
        logic       on_set;
        logic [4:0] addr;
        logic [2:0] bitsel;
        logic [1:0] words;
    } skip_info_t;

    // True when a word is the first half of a two-word jump or call.
    function automatic logic is_long_word(input logic [INSTR_W-1:0] w);
        return (w[15:9] == 7'b1001010) && (w[3:2] == 2'b11);
    endfunction

    function automatic op_kind_e decode_kind(input logic [INSTR_W-1:0] w);
        op_kind_e k;
        casez (w)
            16'h9409:               k = OP_ZJ;
            16'h9419:               k = OP_XJ;
            16'h9509:               k = OP_ZC;
            16'h9519:               k = OP_XC;
            16'h9508:               k = OP_RET;
            16'h9518:               k = OP_RETI;
            16'b1100_????_????_????: k = OP_RELJ;
            16'b1101_????_????_????: k = OP_RELC;
            16'b1001_010?_????_110?: k = OP_ABSJ;
            16'b1001_010?_????_111?: k = OP_ABSC;
            16'b1111_00??_????_????: k = OP_BSET;
            16'b1111_01??_????_????: k = OP_BCLR;
            16'b1111_110?_????_0???: k = OP_RSKC;
            16'b1111_111?_????_0???: k = OP_RSKS;
            16'b1001_1001_????_????: k = OP_ISKC;
            16'b1001_1011_????_????: k = OP_ISKS;
            default:                k = OP_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cfd_opdecode.sv
module cfd_opdecode
    import cfd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [FEAT_W-1:0]  feat_i,
    output op_kind_e           kind_o,
    output logic               gated_o,
    output logic               two_word_o
);
    op_kind_e raw;

    always_comb begin
        raw        = decode_kind(instr_i);
        kind_o     = raw;
        two_word_o = (raw == OP_ABSJ) || (raw == OP_ABSC);
        unique case (raw)
            OP_ABSJ, OP_ABSC: gated_o = !feat_i[FEAT_LONG];
            OP_ZJ, OP_ZC:     gated_o = !feat_i[FEAT_IND];
            OP_XJ, OP_XC:     gated_o = !feat_i[FEAT_EXT];
            default:          gated_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfd_addrgen.sv
module cfd_addrgen #(
    parameter int PC_W = 22
) (
    input  logic [11:0]      off12_i,
    input  logic [6:0]       off7_i,
    input  logic [5:0]       long_hi_i,
    input  logic [15:0]      next_word_i,
    input  logic [PC_W-1:0]  npc_i,
    input  logic [15:0]      z_i,
    input  logic [PC_W-17:0] eind_i,
    output logic [PC_W-1:0]  rel_tgt_o,
    output logic [PC_W-1:0]  br_tgt_o,
    output logic [PC_W-1:0]  long_tgt_o,
    output logic [PC_W-1:0]  ind_tgt_o,
    output logic [PC_W-1:0]  ext_tgt_o,
    output logic [PC_W-1:0]  seq1_o,
    output logic [PC_W-1:0]  seq2_o
);
    localparam int LONG_W = 22;
    localparam int EXT_W  = PC_W - 16;

    logic [LONG_W-1:0] long_raw;
    logic [PC_W-1:0]   off12_x;
    logic [PC_W-1:0]   off7_x;

    assign off12_x  = {{(PC_W-12){off12_i[11]}}, off12_i};
    assign off7_x   = {{(PC_W-7){off7_i[6]}}, off7_i};
    assign long_raw = {long_hi_i, next_word_i};

    // All candidate targets are formed side by side; the top picks one.
    assign rel_tgt_o = npc_i + off12_x;
    assign br_tgt_o  = npc_i + off7_x;
    assign seq1_o    = npc_i + PC_W'(1);
    assign seq2_o    = npc_i + PC_W'(2);
    assign ind_tgt_o = {{EXT_W{1'b0}}, z_i};
    assign ext_tgt_o = {eind_i, z_i};

    generate
        if (PC_W >= LONG_W) begin : g_long_full
            assign long_tgt_o = PC_W'(long_raw);
        end else begin : g_long_cut
            assign long_tgt_o = long_raw[PC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cfd_condsel.sv
module cfd_condsel
    import cfd_pkg::*;
(
    input  op_kind_e           kind_i,
    input  logic [FLAG_W-1:0]  flags_i,
    input  logic [2:0]         bsel_i,
    input  logic [4:0]         reg_addr_i,
    input  logic [4:0]         io_addr_i,
    input  logic               follow_long_i,
    output logic               br_taken_o,
    output logic               is_skip_o,
    output skip_info_t         skip_o
);
    logic flag_val;

    always_comb begin
        flag_val   = flags_i[bsel_i];
        br_taken_o = 1'b0;
        if (kind_i == OP_BSET) br_taken_o = flag_val;
        if (kind_i == OP_BCLR) br_taken_o = !flag_val;

        is_skip_o = (kind_i == OP_RSKC) || (kind_i == OP_RSKS) ||
                    (kind_i == OP_ISKC) || (kind_i == OP_ISKS);
        skip_o    = '0;
        if (is_skip_o) begin
            skip_o.from_io = (kind_i == OP_ISKC) || (kind_i == OP_ISKS);
            skip_o.on_set  = (kind_i == OP_RSKS) || (kind_i == OP_ISKS);
            skip_o.addr    = skip_o.from_io ? io_addr_i : reg_addr_i;
            skip_o.bitsel  = bsel_i;
            skip_o.words   = follow_long_i ? 2'd2 : 2'd1;
        end
    end
endmodule

// File: rtl/cf_decoder.sv
module cf_decoder
    import cfd_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [15:0]      instr_i,
    input  logic [15:0]      next_word_i,
    input  logic [PC_W-1:0]  npc_i,
    input  logic [15:0]      z_i,
    input  logic [PC_W-17:0] eind_i,
    input  logic [7:0]       flags_i,
    input  logic [2:0]       feat_i,
    output logic             valid_o,
    output logic [2:0]       class_o,
    output logic [PC_W-1:0]  target_o,
    output logic [PC_W-1:0]  ret_addr_o,
    output logic             taken_o,
    output logic             nop_o,
    output logic             skip_io_o,
    output logic             skip_on_set_o,
    output logic [4:0]       skip_addr_o,
    output logic [2:0]       skip_bit_o,
    output logic [1:0]       skip_words_o
);
    op_kind_e   kind;
    logic       gated, two_word, follow_long;
    logic       br_taken, is_skip;
    skip_info_t skip;
    logic [PC_W-1:0] rel_tgt, br_tgt, long_tgt, ind_tgt, ext_tgt, seq1, seq2;

    cf_class_e       n_class;
    logic [PC_W-1:0] n_target, n_ret;
    logic            n_nop;

    assign follow_long = is_long_word(next_word_i);

    cfd_opdecode u_dec (
        .instr_i    (instr_i),
        .feat_i     (feat_i),
        .kind_o     (kind),
        .gated_o    (gated),
        .two_word_o (two_word)
    );

    cfd_addrgen #(.PC_W(PC_W)) u_addr (
        .off12_i     (instr_i[11:0]),
        .off7_i      (instr_i[9:3]),
        .long_hi_i   ({instr_i[8:4], instr_i[0]}),
        .next_word_i (next_word_i),
        .npc_i       (npc_i),
        .z_i         (z_i),
        .eind_i      (eind_i),
        .rel_tgt_o   (rel_tgt),
        .br_tgt_o    (br_tgt),
        .long_tgt_o  (long_tgt),
        .ind_tgt_o   (ind_tgt),
        .ext_tgt_o   (ext_tgt),
        .seq1_o      (seq1),
        .seq2_o      (seq2)
    );

    cfd_condsel u_cond (
        .kind_i        (kind),
        .flags_i       (flags_i),
        .bsel_i        (instr_i[2:0]),
        .reg_addr_i    (instr_i[8:4]),
        .io_addr_i     (instr_i[7:3]),
        .follow_long_i (follow_long),
        .br_taken_o    (br_taken),
        .is_skip_o     (is_skip),
        .skip_o        (skip)
    );

    always_comb begin
        n_class  = CF_OTHER;
        n_target = npc_i;
        n_ret    = '0;
        n_nop    = 1'b0;
        if (gated) begin
            n_nop    = 1'b1;
            n_target = two_word ? seq1 : npc_i;
        end else begin
            unique case (kind)
                OP_RELJ: begin n_class = CF_JUMP; n_target = rel_tgt; end
                OP_RELC: begin n_class = CF_CALL; n_target = rel_tgt; n_ret = npc_i; end
                OP_ABSJ: begin n_class = CF_JUMP; n_target = long_tgt; end
                OP_ABSC: begin n_class = CF_CALL; n_target = long_tgt; n_ret = seq1; end
                OP_ZJ:   begin n_class = CF_JUMP; n_target = ind_tgt; end
                OP_ZC:   begin n_class = CF_CALL; n_target = ind_tgt; n_ret = npc_i; end
                OP_XJ:   begin n_class = CF_JUMP; n_target = ext_tgt; end
                OP_XC:   begin n_class = CF_CALL; n_target = ext_tgt; n_ret = npc_i; end
                OP_RET:  n_class = CF_RET;
                OP_RETI: n_class = CF_RETI;
                OP_BSET, OP_BCLR: begin
                    n_class  = CF_BRANCH;
                    n_target = br_taken ? br_tgt : npc_i;
                end
                default: begin
                    if (is_skip) begin
                        n_class  = CF_SKIP;
                        n_target = (skip.words == 2'd2) ? seq2 : seq1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o       <= 1'b0;
            class_o       <= '0;
            target_o      <= '0;
            ret_addr_o    <= '0;
            taken_o       <= 1'b0;
            nop_o         <= 1'b0;
            skip_io_o     <= 1'b0;
            skip_on_set_o <= 1'b0;
            skip_addr_o   <= '0;
            skip_bit_o    <= '0;
            skip_words_o  <= '0;
        end else begin
            valid_o       <= valid_i;
            class_o       <= n_class;
            target_o      <= n_target;
            ret_addr_o    <= n_ret;
            taken_o       <= br_taken;
            nop_o         <= n_nop;
            skip_io_o     <= skip.from_io;
            skip_on_set_o <= skip.on_set;
            skip_addr_o   <= skip.addr;
            skip_bit_o    <= skip.bitsel;
            skip_words_o  <= skip.words;
        end
    end

    // R11: one result per accepted word, one clock later
    a_r11_result_follows: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R5: taken only reported for branches
    a_r5_taken_is_branch: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> class_o == CF_BRANCH);
    // R5: a branch not taken keeps the sequential address
    a_r5_not_taken_seq: assert property (@(posedge clk) disable iff (rst)
        (valid_o && class_o == CF_BRANCH && !taken_o) |-> target_o == $past(npc_i));
    // R8: a disabled instruction never transfers control
    a_r8_nop_other: assert property (@(posedge clk) disable iff (rst)
        nop_o |-> class_o == CF_OTHER);
    // R9: skip target sits skip_words past the following address
    a_r9_skip_span: assert property (@(posedge clk) disable iff (rst)
        (valid_o && class_o == CF_SKIP) |->
        ((skip_words_o == 2'd1 || skip_words_o == 2'd2) &&
         (target_o - $past(npc_i)) == PC_W'(skip_words_o)));
    // R6: return address is the following address or one past it
    a_r6_call_ret: assert property (@(posedge clk) disable iff (rst)
        (valid_o && class_o == CF_CALL) |->
        (ret_addr_o == $past(npc_i) || ret_addr_o == $past(npc_i) + PC_W'(1)));
endmodule

// File: tb/test_cf_decoder.sv
module test_cf_decoder;
    localparam int PC_W = 22;

    typedef struct {
        logic [2:0]      cls;
        logic [PC_W-1:0] tgt;
        logic [PC_W-1:0] ret;
        logic            taken;
        logic            nop;
        logic            sio;
        logic            sset;
        logic [4:0]      saddr;
        logic [2:0]      sbit;
        logic [1:0]      swords;
        string           tag;
    } exp_t;

    logic clk = 0, rst = 1, valid_i = 0;
    logic [15:0] instr_i = 0, next_word_i = 0, z_i = 0;
    logic [PC_W-1:0] npc_i = 0;
    logic [PC_W-17:0] eind_i = 0;
    logic [7:0] flags_i = 0;
    logic [2:0] feat_i = 3'b111;
    logic valid_o, taken_o, nop_o, skip_io_o, skip_on_set_o;
    logic [2:0] class_o, skip_bit_o;
    logic [PC_W-1:0] target_o, ret_addr_o;
    logic [4:0] skip_addr_o;
    logic [1:0] skip_words_o;

    int checks = 0, fails = 0;
    bit finished = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    cf_decoder #(.PC_W(PC_W)) i_cf_decoder (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .next_word_i(next_word_i), .npc_i(npc_i), .z_i(z_i), .eind_i(eind_i),
        .flags_i(flags_i), .feat_i(feat_i), .valid_o(valid_o), .class_o(class_o),
        .target_o(target_o), .ret_addr_o(ret_addr_o), .taken_o(taken_o),
        .nop_o(nop_o), .skip_io_o(skip_io_o), .skip_on_set_o(skip_on_set_o),
        .skip_addr_o(skip_addr_o), .skip_bit_o(skip_bit_o), .skip_words_o(skip_words_o)
    );

    function automatic exp_t mk(logic [2:0] c, logic [PC_W-1:0] t, logic [PC_W-1:0] r,
                                logic tk, logic n, string tag);
        exp_t e;
        e.cls = c; e.tgt = t; e.ret = r; e.taken = tk; e.nop = n;
        e.sio = 0; e.sset = 0; e.saddr = 0; e.sbit = 0; e.swords = 0; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t mks(logic [PC_W-1:0] t, logic io, logic st, logic [4:0] a,
                                 logic [2:0] b, logic [1:0] w, string tag);
        exp_t e;
        e = mk(3'd6, t, '0, 0, 0, tag);
        e.sio = io; e.sset = st; e.saddr = a; e.sbit = b; e.swords = w;
        return e;
    endfunction

    task automatic send(logic [15:0] w, logic [15:0] w2, logic [PC_W-1:0] npc,
                        logic [7:0] fl, logic [2:0] ft, exp_t e);
        @(negedge clk);
        valid_i = 1; instr_i = w; next_word_i = w2; npc_i = npc;
        flags_i = fl; feat_i = ft;
        q.push_back(e);
        @(negedge clk);
        valid_i = 0;
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            exp_t e;
            logic [60:0] act, exv;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected result act_class=%0d exp=none", class_o);
            end else begin
                e = q.pop_front();
                act = {class_o, target_o, ret_addr_o, taken_o, nop_o, skip_io_o,
                       skip_on_set_o, skip_addr_o, skip_bit_o, skip_words_o};
                exv = {e.cls, e.tgt, e.ret, e.taken, e.nop, e.sio, e.sset,
                       e.saddr, e.sbit, e.swords};
                if (act !== exv) begin
                    fails++;
                    $display("FAIL %s act=%h exp=%h", e.tag, act, exv);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        z_i = 16'hBEEF; eind_i = 6'h03;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        @(negedge clk);
        // R11: reset state
        checks++;
        if (valid_o !== 0 || class_o !== 0 || target_o !== 0) begin
            fails++;
            $display("FAIL R11 reset act=%b/%0d/%h exp=0/0/0", valid_o, class_o, target_o);
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if (valid_o !== 0) begin
            fails++;
            $display("FAIL R11 idle valid act=%b exp=0", valid_o);
        end

        // R1 relative jump forward/backward, R10 wrap
        send(16'hC005, 0, 22'd100, 0, 3'b111, mk(1, 22'd105, 0, 0, 0, "R1 rjmp fwd"));
        send(16'hCFFF, 0, 22'd100, 0, 3'b111, mk(1, 22'd99, 0, 0, 0, "R1 rjmp back"));
        send(16'hCFFE, 0, 22'd0, 0, 3'b111, mk(1, 22'h3FFFFE, 0, 0, 0, "R10 rjmp wrap"));
        // R1/R6 relative call
        send(16'hD010, 0, 22'd200, 0, 3'b111, mk(2, 22'd216, 22'd200, 0, 0, "R1 R6 rcall"));
        // R2 long jump/call, R6 return after two words
        send(16'h955D, 16'h1234, 22'd300, 0, 3'b111, mk(1, 22'h2B1234, 0, 0, 0, "R2 jmp"));
        send(16'h955F, 16'h1234, 22'd300, 0, 3'b111, mk(2, 22'h2B1234, 22'd301, 0, 0, "R2 R6 call"));
        send(16'h940C, 16'hFFFF, 22'h3FFFFF, 0, 3'b111, mk(1, 22'h00FFFF, 0, 0, 0, "R2 jmp low"));
        // R8 feature gating
        send(16'h955D, 16'h1234, 22'd300, 0, 3'b110, mk(0, 22'd301, 0, 0, 1, "R8 jmp off"));
        send(16'h955F, 16'h1234, 22'd300, 0, 3'b110, mk(0, 22'd301, 0, 0, 1, "R8 call off"));
        send(16'h9409, 0, 22'd40, 0, 3'b101, mk(0, 22'd40, 0, 0, 1, "R8 ijmp off"));
        send(16'h9519, 0, 22'd40, 0, 3'b011, mk(0, 22'd40, 0, 0, 1, "R8 eicall off"));
        // R3 indirect forms
        send(16'h9409, 0, 22'd40, 0, 3'b111, mk(1, 22'h00BEEF, 0, 0, 0, "R3 ijmp"));
        send(16'h9419, 0, 22'd40, 0, 3'b111, mk(1, 22'h03BEEF, 0, 0, 0, "R3 eijmp"));
        send(16'h9509, 0, 22'd50, 0, 3'b111, mk(2, 22'h00BEEF, 22'd50, 0, 0, "R3 R6 icall"));
        send(16'h9519, 0, 22'd50, 0, 3'b111, mk(2, 22'h03BEEF, 22'd50, 0, 0, "R3 R6 eicall"));
        // R4 returns
        send(16'h9508, 0, 22'd77, 0, 3'b111, mk(3, 22'd77, 0, 0, 0, "R4 ret"));
        send(16'h9518, 0, 22'd78, 0, 3'b111, mk(4, 22'd78, 0, 0, 0, "R4 reti"));
        // R5 branches: Z is index 1, I is index 7, C is index 0
        send(16'hF019, 0, 22'd500, 8'h02, 3'b111, mk(5, 22'd503, 0, 1, 0, "R5 brbs Z set"));
        send(16'hF019, 0, 22'd500, 8'hFD, 3'b111, mk(5, 22'd500, 0, 0, 0, "R5 brbs Z clear"));
        send(16'hF419, 0, 22'd500, 8'h00, 3'b111, mk(5, 22'd503, 0, 1, 0, "R5 brbc Z clear"));
        send(16'hF419, 0, 22'd500, 8'h02, 3'b111, mk(5, 22'd500, 0, 0, 0, "R5 brbc Z set"));
        send(16'hF3E7, 0, 22'd500, 8'h80, 3'b111, mk(5, 22'd496, 0, 1, 0, "R5 brbs I back"));
        send(16'hF3E7, 0, 22'd500, 8'h7F, 3'b111, mk(5, 22'd500, 0, 0, 0, "R5 brbs I clear"));
        send(16'hF018, 0, 22'h3FFFFF, 8'h01, 3'b111, mk(5, 22'd2, 0, 1, 0, "R10 R5 brbs C wrap"));
        // R7 / R9 skips
        send(16'hFD15, 16'h0000, 22'd600, 0, 3'b111, mks(22'd601, 0, 0, 5'd17, 3'd5, 2'd1, "R7 sbrc"));
        send(16'hFE30, 16'h940E, 22'd600, 0, 3'b111, mks(22'd602, 0, 1, 5'd3, 3'd0, 2'd2, "R9 sbrs over call"));
        send(16'h99FF, 16'h940C, 22'd700, 0, 3'b111, mks(22'd702, 1, 0, 5'd31, 3'd7, 2'd2, "R7 R9 sbic over jmp"));
        send(16'h9B02, 16'h9409, 22'd700, 0, 3'b111, mks(22'd701, 1, 1, 5'd0, 3'd2, 2'd1, "R7 sbis"));
        // R12 other words
        send(16'h0000, 0, 22'd800, 8'hFF, 3'b111, mk(0, 22'd800, 0, 0, 0, "R12 nop word"));
        send(16'h1C01, 0, 22'd801, 8'hFF, 3'b111, mk(0, 22'd801, 0, 0, 0, "R12 alu word"));

        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R11 missing results act=%0d exp=0", q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule